// File: doc/BRIEF.md
# Search Path Root Verifier

This block checks that a node record and the chain of ancestors above it, all held in untrusted memory, agree with a root digest kept in trusted storage. After a start, the block picks a starting digest. A freshly inserted node, marked by the all-ones counter code, starts from zero. An existing node starts from one compression of its own key, counter and two child digests. The block then walks upward through N path entries. Each entry carries an ancestor's key, the ancestor's counter and the digest of the sibling subtree. For every entry it issues one compression request.

The position of the running digest among the operands depends on a key comparison. If the current key is below the ancestor's key, the running digest goes in the left slot and the sibling in the right. Otherwise the two swap places. After each step the current key becomes the ancestor's key. When the walk ends, the final digest is compared with the trusted root, and a one-cycle done pulse is raised together with a pass flag.

Path entries come through an indexed request/response port. The compression function sits outside the block behind a request/acknowledge port. Both ports hold their request and operands until the response arrives.

Top module: `path_root_verifier`

## Requirements
- R1: After reset, busy, done, pass, the compression request and the entry request are all low.
- R2: A start is accepted only while busy is low. Busy then stays high through the cycle that carries done, and a start raised while busy has no effect on the result.
- R3: When the node counter equals the all-ones code, the starting digest is zero and no compression is requested for the node itself, so exactly N compressions are issued.
- R4: For any other counter value, the first compression carries the node key, the node counter, the left child digest (left slot) and the right child digest (right slot), so exactly N+1 compressions are issued.
- R5: Entries are fetched one per step, with indices N−1 down to 0 in that order and no others.
- R6: Each step's compression carries the entry key and entry counter. The left slot holds the running digest and the right slot the sibling digest when the current key is less than the entry key (unsigned); otherwise the two slots are swapped.
- R7: After each step the current key takes the value of that step's entry key.
- R8: Done is a single-cycle pulse, and pass is high only while done is high, exactly when the final digest equals the root captured at start.
- R9: With N = 0, the starting digest is compared with the root directly and no entry is fetched.
- R10: A compression request and an entry request, once raised, stay high with stable operands or index until their acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a verification (accepted when not busy) |
| node_key | input | KEY_W | Key of the node being verified |
| node_ctr | input | CTR_W | Counter of the node; all ones marks a new node |
| node_left | input | DIG_W | Left child digest of the node |
| node_right | input | DIG_W | Right child digest of the node |
| path_len | input | LEN_W | Number of path entries N (at most MAX_DEPTH) |
| trusted_root | input | DIG_W | Trusted root digest, captured at start |
| ent_req | output | 1 | Path entry request |
| ent_idx | output | IDX_W | Index of the requested entry |
| ent_valid | input | 1 | Entry response strobe |
| ent_key | input | KEY_W | Ancestor key of the returned entry |
| ent_ctr | input | CTR_W | Ancestor counter of the returned entry |
| ent_sib | input | DIG_W | Sibling digest of the returned entry |
| hreq | output | 1 | Compression request |
| hkey | output | KEY_W | Key operand |
| hctr | output | CTR_W | Counter operand |
| hleft | output | DIG_W | Left digest operand |
| hright | output | DIG_W | Right digest operand |
| hack | input | 1 | Compression acknowledge |
| hdigest | input | DIG_W | Compression result, valid with hack |
| busy | output | 1 | Verification in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Final digest matched the root (valid with done) |

## Verification
The bench builds the block with 4-bit keys, 3-bit counters, 12-bit digests and a depth limit of 4. With these values every path length from 0 to the limit can be swept for both new and existing nodes. Random 4-bit keys then produce a dense mix of left/right orderings at every level. Matching and mismatching roots are both tried for each case. A narrow, non-symmetric mixing function stands in for the hash, so a wrong operand order or a skipped key update changes the final digest.

// File: rtl/path_root_verifier.sv
module path_root_verifier #(
  parameter int KEY_W     = 8,
  parameter int CTR_W     = 4,
  parameter int DIG_W     = 32,
  parameter int MAX_DEPTH = 16,
  localparam int LEN_W    = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] node_key,
  input  logic [CTR_W-1:0] node_ctr,
  input  logic [DIG_W-1:0] node_left,
  input  logic [DIG_W-1:0] node_right,
  input  logic [LEN_W-1:0] path_len,
  input  logic [DIG_W-1:0] trusted_root,
  output logic             ent_req,
  output logic [IDX_W-1:0] ent_idx,
  input  logic             ent_valid,
  input  logic [KEY_W-1:0] ent_key,
  input  logic [CTR_W-1:0] ent_ctr,
  input  logic [DIG_W-1:0] ent_sib,
  output logic             hreq,
  output logic [KEY_W-1:0] hkey,
  output logic [CTR_W-1:0] hctr,
  output logic [DIG_W-1:0] hleft,
  output logic [DIG_W-1:0] hright,
  input  logic             hack,
  input  logic [DIG_W-1:0] hdigest,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  localparam logic [CTR_W-1:0] NEW_CODE = '1;

  typedef enum logic [2:0] {IDLE, SELF, FETCH, STEP, FINAL} st_t;
  st_t st;

  logic [KEY_W-1:0] cur_key, e_key;
  logic [CTR_W-1:0] e_ctr;
  logic [DIG_W-1:0] dig, sib, root;
  logic [IDX_W-1:0] idx;
  logic             no_path;

  wire go_left = cur_key < e_key;

  assign busy    = st != IDLE;
  assign done    = st == FINAL;
  assign pass    = done && (dig == root);
  assign ent_req = st == FETCH;
  assign ent_idx = idx;
  assign hreq    = (st == SELF) || (st == STEP);
  assign hkey    = e_key;
  assign hctr    = e_ctr;
  assign hleft   = (st == SELF || go_left) ? dig : sib;
  assign hright  = (st == SELF || go_left) ? sib : dig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cur_key <= '0;
      e_key   <= '0;
      e_ctr   <= '0;
      dig     <= '0;
      sib     <= '0;
      root    <= '0;
      idx     <= '0;
      no_path <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          cur_key <= node_key;
          e_key   <= node_key;
          e_ctr   <= node_ctr;
          sib     <= node_right;
          root    <= trusted_root;
          no_path <= path_len == '0;
          idx     <= IDX_W'(path_len - LEN_W'(1));
          if (node_ctr == NEW_CODE) begin
            dig <= '0;
            st  <= (path_len == '0) ? FINAL : FETCH;
          end else begin
            dig <= node_left;
            st  <= SELF;
          end
        end
        SELF: if (hack) begin
          dig <= hdigest;
          st  <= no_path ? FINAL : FETCH;
        end
        FETCH: if (ent_valid) begin
          e_key <= ent_key;
          e_ctr <= ent_ctr;
          sib   <= ent_sib;
          st    <= STEP;
        end
        STEP: if (hack) begin
          dig     <= hdigest;
          cur_key <= e_key;
          if (idx == '0) st <= FINAL;
          else begin
            idx <= idx - IDX_W'(1);
            st  <= FETCH;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/path_root_verifier_chk.sv
module path_root_verifier_chk #(
  parameter int KEY_W = 8,
  parameter int CTR_W = 4,
  parameter int DIG_W = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             hreq,
  input logic             hack,
  input logic [KEY_W-1:0] hkey,
  input logic [CTR_W-1:0] hctr,
  input logic [DIG_W-1:0] hleft,
  input logic [DIG_W-1:0] hright,
  input logic             ent_req,
  input logic             ent_valid,
  input logic [IDX_W-1:0] ent_idx
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  pass_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) pass |-> done);
  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));
  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({hreq, ent_req, done}));
  // R10
  hreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq && !hack |=> hreq && $stable(hkey) && $stable(hctr) && $stable(hleft) && $stable(hright));
  // R10
  ent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_req && !ent_valid |=> ent_req && $stable(ent_idx));
endmodule

bind path_root_verifier path_root_verifier_chk #(
  .KEY_W(KEY_W), .CTR_W(CTR_W), .DIG_W(DIG_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass),
  .hreq(hreq), .hack(hack), .hkey(hkey), .hctr(hctr), .hleft(hleft), .hright(hright),
  .ent_req(ent_req), .ent_valid(ent_valid), .ent_idx(ent_idx)
);

// File: tb/path_root_verifier_tb.sv
module path_root_verifier_tb;
  localparam int KW = 4, CW = 3, DW = 12, MD = 4;
  localparam int LW = $clog2(MD + 1), IW = $clog2(MD);

  logic clk = 0, rst_n = 0, start = 0;
  logic [KW-1:0] node_key = 0, ent_key, hkey;
  logic [CW-1:0] node_ctr = 0, ent_ctr, hctr;
  logic [DW-1:0] node_left = 0, node_right = 0, trusted_root = 0, ent_sib, hleft, hright, hdigest = 0;
  logic [LW-1:0] path_len = 0;
  logic [IW-1:0] ent_idx;
  logic ent_req, ent_valid = 0, hreq, hack = 0, busy, done, pass;

  logic [KW-1:0] tk [MD];
  logic [CW-1:0] tc [MD];
  logic [DW-1:0] ts [MD];

  int checks = 0, fails = 0, cyc = 0;
  int hcount = 0, fcount = 0, exp_idx = 0, idx_bad = 0;
  logic [KW+CW+2*DW-1:0] first_ops;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  path_root_verifier #(.KEY_W(KW), .CTR_W(CW), .DIG_W(DW), .MAX_DEPTH(MD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .node_key(node_key), .node_ctr(node_ctr),
    .node_left(node_left), .node_right(node_right), .path_len(path_len),
    .trusted_root(trusted_root), .ent_req(ent_req), .ent_idx(ent_idx), .ent_valid(ent_valid),
    .ent_key(ent_key), .ent_ctr(ent_ctr), .ent_sib(ent_sib), .hreq(hreq), .hkey(hkey),
    .hctr(hctr), .hleft(hleft), .hright(hright), .hack(hack), .hdigest(hdigest),
    .busy(busy), .done(done), .pass(pass));

  function automatic logic [DW-1:0] mix(logic [KW-1:0] k, logic [CW-1:0] c, logic [DW-1:0] l, logic [DW-1:0] r);
    logic [DW-1:0] t;
    t = {l[8:0], l[11:9]} ^ (r * 12'd5);
    t = t + {k, k, k} + ({9'd0, c} * 12'd397);
    return t ^ {t[4:0], t[11:5]};
  endfunction

  function automatic logic [DW-1:0] ref_root(int n);
    logic [DW-1:0] d;
    logic [KW-1:0] ck;
    ck = node_key;
    d = (node_ctr == 3'b111) ? '0 : mix(node_key, node_ctr, node_left, node_right);
    for (int i = n - 1; i >= 0; i--) begin
      d = (ck < tk[i]) ? mix(tk[i], tc[i], d, ts[i]) : mix(tk[i], tc[i], ts[i], d);
      ck = tk[i];
    end
    return d;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  assign ent_key = tk[ent_idx];
  assign ent_ctr = tc[ent_idx];
  assign ent_sib = ts[ent_idx];

  always @(negedge clk) begin
    ent_valid <= ent_req && !ent_valid;
    hack      <= hreq && !hack;
    hdigest   <= mix(hkey, hctr, hleft, hright);
  end

  always @(posedge clk) begin
    cyc++;
    if (hreq && hack) begin
      if (hcount == 0) first_ops <= {hkey, hctr, hleft, hright};
      hcount++;
    end
    if (ent_req && ent_valid) begin
      if (int'(ent_idx) != exp_idx) idx_bad++;
      exp_idx--;
      fcount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input bit poke, input bit good);
    logic [DW-1:0] r;
    int w;
    bit is_new;
    is_new = node_ctr == 3'b111;
    r = ref_root(n);
    @(negedge clk);
    hcount = 0; fcount = 0; idx_bad = 0; exp_idx = n - 1;
    path_len = LW'(n);
    trusted_root = good ? r : r ^ 12'h001;
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke && !done) begin
      start = 1; node_key = node_key ^ 4'h5; trusted_root = ~trusted_root;
      @(negedge clk);
      start = 0; node_key = node_key ^ 4'h5; trusted_root = ~trusted_root;
    end
    w = 0;
    while (!done && w < 500) begin @(negedge clk); w++; end
    check(done, "R2 done reached", done, 1);
    // R6 R7 R8 R9: result vs independently computed root
    check(pass == good, poke ? "R2 start ignored while busy" : (n == 0 ? "R9 direct compare" : "R6/R7/R8 pass flag"), pass, good);
    @(negedge clk);
    check(!done && !pass, "R8 single pulse", done, 0);
    check(hcount == n + (is_new ? 0 : 1), is_new ? "R3 compression count" : "R4 compression count",
          hcount, n + (is_new ? 0 : 1));
    check(fcount == n && idx_bad == 0, n == 0 ? "R9 no fetch" : "R5 fetch order", fcount, n);
    if (!is_new)
      check(first_ops == {node_key, node_ctr, node_left, node_right}, "R4 node operands",
            int'(first_ops[DW-1:0]), int'(node_right));
  endtask

  initial begin
    for (int i = 0; i < MD; i++) begin tk[i] = 0; tc[i] = 0; ts[i] = 0; end
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !pass && !hreq && !ent_req, "R1 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !hreq && !ent_req, "R1 idle after reset", busy, 0);
    for (int n = 0; n <= MD; n++)
      for (int kind = 0; kind < 2; kind++)
        for (int t = 0; t < 4; t++)
          for (int g = 0; g < 2; g++) begin
            node_key = KW'(rnd());
            node_ctr = kind == 0 ? 3'b111 : CW'(rnd() % 7);
            node_left = DW'(rnd());
            node_right = DW'(rnd());
            for (int i = 0; i < MD; i++) begin
              tk[i] = KW'(rnd() >> 7); tc[i] = CW'(rnd() >> 5); ts[i] = DW'(rnd() >> 3);
            end
            run(n, t == 3 && n >= 2, g == 1);
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule